// File: doc/BRIEF.md
# HDLC Transmit Segmenter

This block takes one outgoing signalling-channel frame at a time and feeds it to an HDLC transmit pool in pieces of at most 32 bytes. Frame bytes arrive as a byte stream. A separate end strobe closes the frame and asks for it to be sent. While the line is active, the block holds the frame in a local buffer and starts the first piece at once. After each piece it issues a transmit command byte. The command marks the piece either as a continuation or as the end of the message.

The pool reports three kinds of event back to the block. A ready event asks for the next piece, or confirms the frame once nothing is left to send. A repeat request or an underrun moves the read position back to the first byte of the frame, so the next ready event sends the frame again from its start. Only one frame can be held at a time. A new request while a frame is held is refused with an error pulse. So is a request that carries no bytes.

Top module: `hdlc_tx_segmenter`

## Requirements
- R1: While reset is held and on the first cycle after it, pool_we, cmd_we, confirm and req_err are all low.
- R2: A piece is followed by command byte 0x08 (only bit 3, transmit-continue, set) when frame bytes remain after it. In that case the piece holds exactly 32 bytes.
- R3: The last piece of a frame holds 1 to 32 bytes. It is followed by command byte 0x0A (bit 3 transmit-continue and bit 1 message-end both set).
- R4: An accepted frame's first piece starts without any ready event. Bytes go out one per pool_we cycle, in the order they arrived.
- R5: A ready event while the block waits sends the next piece if bytes remain. If none remain, confirm rises for exactly one cycle and the frame is released.
- R6: A repeat or underrun event while the block waits moves the read position back to the frame's first byte. The next ready event then sends the frame again from byte 0.
- R7: A request made while line_active is low is discarded. Nothing is sent and its bytes are dropped, so the next frame holds only its own bytes.
- R8: An end strobe while a frame is held gives a one-cycle req_err pulse. The held frame is then sent unchanged.
- R9: An end strobe with no bytes collected gives a one-cycle req_err pulse and sends nothing.
- R10: Ready, repeat and underrun events while no frame is held have no effect. They produce no output and no confirm.
- R11: When ready and repeat (or underrun) arrive in the same cycle, the rewind is applied first. The piece sent then starts at byte 0, even after the whole frame has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_active | input | 1 | Layer-1 link is in its active state |
| in_valid | input | 1 | in_data carries a frame byte |
| in_data | input | 8 | Frame byte |
| in_end | input | 1 | Closes the collected bytes into a send request |
| ev_ready | input | 1 | Transmit pool ready for more data |
| ev_repeat | input | 1 | Pool asks for the message to be repeated |
| ev_underrun | input | 1 | Pool ran dry during the message |
| pool_we | output | 1 | pool_data is valid this cycle |
| pool_data | output | 8 | Byte written to the transmit pool |
| cmd_we | output | 1 | cmd_data is valid this cycle |
| cmd_data | output | 8 | Transmit command byte |
| confirm | output | 1 | One-cycle pulse: frame fully sent and released |
| req_err | output | 1 | One-cycle pulse: request refused |

## Verification
The two functions that can fall in the same cycle are the rewind and the loading of the next piece. The case is provoked by driving ev_ready together with ev_repeat, and later together with ev_underrun, in a single cycle. This is done once after a middle piece and once after the final piece. The scoreboard expects the following piece to start at byte 0 with a continue command, and expects no confirm even though every byte had already gone out.

// File: rtl/hdlc_seg_pkg.sv
package hdlc_seg_pkg;

    localparam int unsigned BYTE_W       = 8;
    // Command byte bit positions decoded by the transmit pool
    localparam int unsigned CMD_BIT_CONT = 3;
    localparam int unsigned CMD_BIT_END  = 1;

    typedef enum logic [1:0] {
        SEG_IDLE,
        SEG_FILL,
        SEG_CMD,
        SEG_WAIT
    } seg_state_e;

    typedef struct packed {
        logic ready;
        logic rewind;
    } seg_evt_t;

    function automatic logic [BYTE_W-1:0] seg_cmd(input logic final_piece);
        logic [BYTE_W-1:0] c;
        c = '0;
        c[CMD_BIT_CONT] = 1'b1;
        c[CMD_BIT_END]  = final_piece;
        return c;
    endfunction

endpackage

// File: rtl/hdlc_seg_buf.sv
module hdlc_seg_buf
    import hdlc_seg_pkg::*;
#(
    parameter  int unsigned DEPTH = 128,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CW-1:0]     count
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              room;

    assign room    = count < CW'(DEPTH);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (wr_en && room) begin
            count <= count + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && room && !clr && !rst) begin
            mem[count[IW-1:0]] <= wr_data;
        end
    end

    // R4: stored bytes never exceed the buffer depth
    p_count_cap_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/hdlc_seg_ctrl.sv
module hdlc_seg_ctrl
    import hdlc_seg_pkg::*;
#(
    parameter  int unsigned DEPTH = 128,
    parameter  int unsigned CHUNK = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned KW    = $clog2(CHUNK + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_active,
    input  logic              req_end,
    input  logic [CW-1:0]     frame_len,
    input  seg_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IW-1:0]     rd_addr,
    output logic              buf_clr,
    output logic              idle,
    output logic              pool_we,
    output logic [BYTE_W-1:0] pool_data,
    output logic              cmd_we,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              confirm,
    output logic              req_err
);

    seg_state_e     state;
    logic [CW-1:0]  len_q;
    logic [CW-1:0]  rd_ptr;
    logic [CW-1:0]  tx_cnt;
    logic [CW-1:0]  eff_ptr;
    logic [CW-1:0]  eff_tx;
    logic [KW-1:0]  piece_cnt;
    logic           piece_full;
    logic           msg_last;
    logic           frame_done;

    always_comb begin
        // A rewind is applied before a same-cycle ready is served
        eff_ptr    = evt.rewind ? (rd_ptr - tx_cnt) : rd_ptr;
        eff_tx     = evt.rewind ? '0 : tx_cnt;
        piece_full = piece_cnt == KW'(CHUNK - 1);
        msg_last   = (rd_ptr + CW'(1)) == len_q;
        frame_done = eff_ptr == len_q;
        idle       = state == SEG_IDLE;
        buf_clr    = (idle && req_end && !line_active)
                   || (state == SEG_WAIT && evt.ready && frame_done);
        rd_addr    = rd_ptr[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEG_IDLE;
            len_q     <= '0;
            rd_ptr    <= '0;
            tx_cnt    <= '0;
            piece_cnt <= '0;
            pool_we   <= 1'b0;
            pool_data <= '0;
            cmd_we    <= 1'b0;
            cmd_data  <= '0;
            confirm   <= 1'b0;
            req_err   <= 1'b0;
        end else begin
            pool_we <= 1'b0;
            cmd_we  <= 1'b0;
            confirm <= 1'b0;
            req_err <= 1'b0;
            if (!idle && req_end) begin
                req_err <= 1'b1;
            end
            unique case (state)
                SEG_IDLE: begin
                    if (req_end) begin
                        if (frame_len == '0) begin
                            req_err <= 1'b1;
                        end else if (line_active) begin
                            len_q     <= frame_len;
                            rd_ptr    <= '0;
                            tx_cnt    <= '0;
                            piece_cnt <= '0;
                            state     <= SEG_FILL;
                        end
                    end
                end
                SEG_FILL: begin
                    pool_we   <= 1'b1;
                    pool_data <= rd_data;
                    rd_ptr    <= rd_ptr + CW'(1);
                    tx_cnt    <= tx_cnt + CW'(1);
                    piece_cnt <= piece_cnt + KW'(1);
                    if (piece_full || msg_last) begin
                        state <= SEG_CMD;
                    end
                end
                SEG_CMD: begin
                    cmd_we   <= 1'b1;
                    cmd_data <= seg_cmd(rd_ptr == len_q);
                    state    <= SEG_WAIT;
                end
                SEG_WAIT: begin
                    if (evt.ready && frame_done) begin
                        confirm <= 1'b1;
                        tx_cnt  <= '0;
                        rd_ptr  <= '0;
                        state   <= SEG_IDLE;
                    end else begin
                        rd_ptr <= eff_ptr;
                        tx_cnt <= eff_tx;
                        if (evt.ready) begin
                            piece_cnt <= '0;
                            state     <= SEG_FILL;
                        end
                    end
                end
                default: state <= SEG_IDLE;
            endcase
        end
    end

    // R4: data and command strobes never share a cycle
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !(pool_we && cmd_we));

    // R3: command byte only ever carries continue, optionally with end
    p_cmd_code_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_we |-> (cmd_data[CMD_BIT_CONT] && ((cmd_data & ~seg_cmd(1'b1)) == '0)));

    // R2: a piece never exceeds the piece size
    p_piece_cap_r2: assert property (@(posedge clk) disable iff (rst)
        piece_cnt <= KW'(CHUNK));

    // R5: confirm lasts a single cycle
    p_confirm_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        confirm |=> !confirm);

    // R6: a lone rewind returns to the frame start
    p_rewind_start_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SEG_WAIT && evt.rewind && !evt.ready) |=> (rd_ptr == '0 && tx_cnt == '0));

    // R10: nothing leaves the block while no frame is held
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state == SEG_IDLE) |-> (!pool_we && !cmd_we));

endmodule

// File: rtl/hdlc_tx_segmenter.sv
module hdlc_tx_segmenter
    import hdlc_seg_pkg::*;
#(
    parameter  int unsigned DEPTH = 128,
    parameter  int unsigned CHUNK = 32,
    localparam int unsigned IW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_active,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_end,
    input  logic        ev_ready,
    input  logic        ev_repeat,
    input  logic        ev_underrun,
    output logic        pool_we,
    output logic [7:0]  pool_data,
    output logic        cmd_we,
    output logic [7:0]  cmd_data,
    output logic        confirm,
    output logic        req_err
);

    seg_evt_t          evt;
    logic              idle;
    logic              buf_clr;
    logic [IW-1:0]     rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic [CW-1:0]     frame_len;

    assign evt.ready  = ev_ready;
    assign evt.rewind = ev_repeat | ev_underrun;

    hdlc_seg_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid && idle),
        .wr_data (in_data),
        .clr     (buf_clr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .count   (frame_len)
    );

    hdlc_seg_ctrl #(.DEPTH(DEPTH), .CHUNK(CHUNK)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .line_active (line_active),
        .req_end     (in_end),
        .frame_len   (frame_len),
        .evt         (evt),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .buf_clr     (buf_clr),
        .idle        (idle),
        .pool_we     (pool_we),
        .pool_data   (pool_data),
        .cmd_we      (cmd_we),
        .cmd_data    (cmd_data),
        .confirm     (confirm),
        .req_err     (req_err)
    );

endmodule

// File: tb/sim_hdlc_tx_segmenter.sv
module sim_hdlc_tx_segmenter;

    logic       clk, rst, line_active, in_valid, in_end;
    logic [7:0] in_data;
    logic       ev_ready, ev_repeat, ev_underrun;
    logic       pool_we, cmd_we, confirm, req_err;
    logic [7:0] pool_data, cmd_data;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic [8:0] exp_q [$];
    logic [8:0] mon_got, mon_exp;

    hdlc_tx_segmenter u0 (
        .clk(clk), .rst(rst), .line_active(line_active),
        .in_valid(in_valid), .in_data(in_data), .in_end(in_end),
        .ev_ready(ev_ready), .ev_repeat(ev_repeat), .ev_underrun(ev_underrun),
        .pool_we(pool_we), .pool_data(pool_data),
        .cmd_we(cmd_we), .cmd_data(cmd_data),
        .confirm(confirm), .req_err(req_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed * 13 + i * 7);
    endfunction

    // Expected items: bit 8 set marks a command byte
    task automatic push_piece(input int seed, input int start, input int n, input bit last);
        for (int i = start; i < start + n; i++) exp_q.push_back({1'b0, byte_of(seed, i)});
        exp_q.push_back({1'b1, last ? 8'h0A : 8'h08});
    endtask

    // Monitor: every strobe is compared against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && (pool_we || cmd_we)) begin
            mon_got = {cmd_we, cmd_we ? cmd_data : pool_data};
            if (exp_q.size() == 0) begin
                chk(1'b0, "stray output R7 R8 R9 R10", int'(mon_got), 0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(mon_got == mon_exp, "stream R2 R3 R4 R6 R11", int'(mon_got), int'(mon_exp));
            end
        end
    end

    task automatic send_bytes(input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = byte_of(seed, i);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic end_req(input bit exp_err, input string req);
        in_end = 1'b1;
        @(negedge clk);
        in_end = 1'b0;
        chk(req_err == exp_err, req, int'(req_err), int'(exp_err));
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(input bit r, input bit rp, input bit ud, input bit exp_conf, input string req);
        @(negedge clk);
        ev_ready = r; ev_repeat = rp; ev_underrun = ud;
        @(negedge clk);
        ev_ready = 1'b0; ev_repeat = 1'b0; ev_underrun = 1'b0;
        chk(confirm == exp_conf, req, int'(confirm), int'(exp_conf));
        if (exp_conf) begin
            @(negedge clk);
            chk(confirm == 1'b0, "R5 confirm single cycle", int'(confirm), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; line_active = 1'b1; in_valid = 1'b0; in_data = '0; in_end = 1'b0;
        ev_ready = 1'b0; ev_repeat = 1'b0; ev_underrun = 1'b0;
        repeat (3) @(negedge clk);
        chk(!pool_we && !cmd_we && !confirm && !req_err, "R1 reset outputs",
            int'({pool_we, cmd_we, confirm, req_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!pool_we && !cmd_we && !confirm && !req_err, "R1 after reset",
            int'({pool_we, cmd_we, confirm, req_err}), 0);

        // R4 R3 R5: short frame goes out at once, confirm on ready
        push_piece(1, 0, 5, 1'b1);
        send_bytes(1, 5);
        end_req(1'b0, "R4 accept short frame");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R5 confirm after last piece");

        // R2: 70 bytes -> 32 + 32 + 6
        push_piece(2, 0, 32, 1'b0);
        send_bytes(2, 70);
        end_req(1'b0, "R2 accept long frame");
        drain();
        push_piece(2, 32, 32, 1'b0);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R5 ready with bytes left");
        drain();
        push_piece(2, 64, 6, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R5 ready with bytes left");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R5 confirm long frame");

        // R3 boundary: exactly 32 bytes is a single final piece
        push_piece(3, 0, 32, 1'b1);
        send_bytes(3, 32);
        end_req(1'b0, "R3 accept 32-byte frame");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R3 confirm 32-byte frame");

        // R2 boundary: 33 bytes -> 32 + 1
        push_piece(4, 0, 32, 1'b0);
        send_bytes(4, 33);
        end_req(1'b0, "R2 accept 33-byte frame");
        drain();
        push_piece(4, 32, 1, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R2 single trailing byte");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R5 confirm 33-byte frame");

        // R6: repeat after first piece, underrun after last piece
        push_piece(5, 0, 32, 1'b0);
        send_bytes(5, 40);
        end_req(1'b0, "R6 accept");
        drain();
        pulse(1'b0, 1'b1, 1'b0, 1'b0, "R6 repeat gives no confirm");
        repeat (3) @(negedge clk);
        push_piece(5, 0, 32, 1'b0);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 resend from start");
        drain();
        push_piece(5, 32, 8, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 continue");
        drain();
        pulse(1'b0, 1'b0, 1'b1, 1'b0, "R6 underrun gives no confirm");
        push_piece(5, 0, 32, 1'b0);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 resend after underrun");
        drain();
        push_piece(5, 32, 8, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R6 continue");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R6 confirm after rewinds");

        // R11: ready together with rewind in one cycle
        push_piece(6, 0, 32, 1'b0);
        send_bytes(6, 40);
        end_req(1'b0, "R11 accept");
        drain();
        push_piece(6, 0, 32, 1'b0);
        pulse(1'b1, 1'b1, 1'b0, 1'b0, "R11 ready+repeat restarts");
        drain();
        push_piece(6, 32, 8, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R11 continue");
        drain();
        push_piece(6, 0, 32, 1'b0);
        pulse(1'b1, 1'b0, 1'b1, 1'b0, "R11 ready+underrun after last piece, no confirm");
        drain();
        push_piece(6, 32, 8, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R11 continue");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R11 confirm");

        // R7: line inactive -> discarded, staging cleared
        line_active = 1'b0;
        send_bytes(7, 4);
        end_req(1'b0, "R7 discard no error");
        repeat (5) @(negedge clk);
        line_active = 1'b1;
        push_piece(8, 0, 3, 1'b1);
        send_bytes(8, 3);
        end_req(1'b0, "R7 next frame accepted");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R7 confirm clean frame");

        // R8: request while a frame is held
        push_piece(9, 0, 32, 1'b0);
        send_bytes(9, 40);
        end_req(1'b0, "R8 accept");
        drain();
        send_bytes(10, 3);
        end_req(1'b1, "R8 busy request error");
        @(negedge clk);
        chk(req_err == 1'b0, "R8 error single cycle", int'(req_err), 0);
        push_piece(9, 32, 8, 1'b1);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R8 held frame continues");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R8 confirm held frame");

        // R9: zero-length request
        @(negedge clk);
        end_req(1'b1, "R9 empty request error");
        repeat (4) @(negedge clk);

        // R10: events with no frame held
        pulse(1'b0, 1'b1, 1'b0, 1'b0, "R10 repeat idle");
        pulse(1'b0, 1'b0, 1'b1, 1'b0, "R10 underrun idle");
        pulse(1'b1, 1'b0, 1'b0, 1'b0, "R10 ready idle no confirm");
        repeat (4) @(negedge clk);
        push_piece(11, 0, 3, 1'b1);
        send_bytes(11, 3);
        end_req(1'b0, "R10 later frame accepted");
        drain();
        pulse(1'b1, 1'b0, 1'b0, 1'b1, "R10 later frame confirm");

        chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule